// File: doc/BRIEF.md
# Multiplexed LCD drive sequencer

This block times and drives a segment LCD panel. A small register bus writes a control byte, a slot prescaler and a pixel array of sixteen bytes. One of three tick sources is chosen and divided down to a per-common time slot. The sequencer visits the active common lines one slot at a time. Every common and segment pin gets a two-bit drive-level code that an external ladder or switch stage turns into a panel voltage. The code runs from 0 (lowest rail, V0) to 3 (highest rail, V3).

Static drive uses only the two outer levels. The 1/2, 1/3 and 1/4 multiplex modes use 1/3 bias, with the intermediate levels V1 and V2. Each frame has two halves of opposite polarity, so that every pixel sees a zero average voltage. Every extra common takes one segment pin away. The voltage-generator enable is only a control bit passed to an output pin.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset the control byte reads 0x00, `vgen_en` is 0, and every common and segment code is 0.
- R2: Bus map: addresses 0..15 hold the pixel bytes, address 16 holds the control byte and address 17 holds the prescaler. All three read back what was written, except that control bit 5 always reads 0. Control bit 4 drives `vgen_en`.
- R3: While control bit 7 (enable) is 0, every common and segment code is 0, and the sequencer is held at common 0 in polarity half A.
- R4: Control bits 1:0 give the last active common: 0 static, 1 for 1/2, 2 for 1/3, 3 for 1/4. Each slot advances the common index by one. After the last active common the index wraps to 0 and the polarity half toggles (A, then B).
- R5: Static mode: common 0 is 3 in half A and 0 in half B. A dark segment takes the opposite extreme. A clear segment takes the same level as common 0. Commons 1..3 stay 0.
- R6: Multiplex modes: the selected common is 3 in half A and 0 in half B. Unselected active commons are 1 in half A and 2 in half B. A dark segment is 0 in half A and 3 in half B. A clear segment is 2 in half A and 1 in half B. Commons beyond the last active one stay 0.
- R7: Segments numbered 32 minus the mux field value and above are held at code 0. This leaves 32, 31, 30 or 29 usable segments.
- R8: The pixel for segment s on common c is bit (s mod 8) of byte 4*c + s/8. A 1 means dark and a 0 means clear.
- R9: Control bits 3:2 select the tick source: 00 is the system clock divided by 256, 01 is each rising edge of `ext_clk`, and 1x is each rising edge of `rc_clk`. The unselected sources have no effect.
- R10: With prescaler value p, one slot occurs every p+1 source ticks.
- R11: If control bit 6 is 1 and `sleep_in` is high, the sequencer stops and holds its outputs. If bit 6 is 0, refresh continues while `sleep_in` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_clk | input | 1 | External timer clock, synchronous to `clk` |
| rc_clk | input | 1 | Internal RC oscillator clock, synchronous to `clk` |
| sleep_in | input | 1 | Device sleep indication |
| com_lvl | output | 8 | Drive codes, common c in bits 2c+1:2c |
| seg_lvl | output | 64 | Drive codes, segment s in bits 2s+1:2s |
| vgen_en | output | 1 | Voltage-generator enable |

## Verification
Some properties hold on every clock cycle, and the assertions check those. When drive is off, all pins are quiet. Static mode uses only the outer levels. A multiplexed frame has exactly one selected active common. Segment pins taken by commons stay at 0. A sleeping sequencer freezes its commons. The reserved control bit reads 0. The directed scenarios cover what needs a reference model over time: the exact level table against a pixel pattern, the common order and polarity toggles in each mode, the divide ratios for the prescaler and for the system clock, and the choice of tick source.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_V0 = 2'd0;
    localparam lvl_t LVL_V1 = 2'd1;
    localparam lvl_t LVL_V2 = 2'd2;
    localparam lvl_t LVL_V3 = 2'd3;

    localparam int CTRL_EN   = 7;
    localparam int CTRL_SLP  = 6;
    localparam int CTRL_RSVD = 5;
    localparam int CTRL_VGEN = 4;

    typedef struct packed {
        logic       en;
        logic       slp;
        logic       vgen;
        logic [1:0] src;
        logic [1:0] mux;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [7:0] b);
        ctrl_t c;
        c.en   = b[CTRL_EN];
        c.slp  = b[CTRL_SLP];
        c.vgen = b[CTRL_VGEN];
        c.src  = b[3:2];
        c.mux  = b[1:0];
        return c;
    endfunction
endpackage

// File: rtl/lcd_regfile.sv
module lcd_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int AW   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic [NREG*DW-1:0] pix,
    output logic [7:0]       ctrl_byte,
    output logic [DW-1:0]    presc
);
    import lcd_seq_pkg::*;
    localparam int ADDR_CTRL  = NREG;
    localparam int ADDR_PRESC = NREG + 1;

    typedef struct packed {
        logic [NREG*DW-1:0] pix;
        logic [7:0]         ctrl;
        logic [DW-1:0]      presc;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we) begin
            if (int'(addr) < NREG) begin
                rf_d.pix[int'(addr)*DW +: DW] = wdata;
            end else if (int'(addr) == ADDR_CTRL) begin
                rf_d.ctrl = wdata[7:0];
                rf_d.ctrl[CTRL_RSVD] = 1'b0;
            end else if (int'(addr) == ADDR_PRESC) begin
                rf_d.presc = wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) < NREG) begin
            rdata = rf_q.pix[int'(addr)*DW +: DW];
        end else if (int'(addr) == ADDR_CTRL) begin
            rdata[7:0] = rf_q.ctrl;
        end else if (int'(addr) == ADDR_PRESC) begin
            rdata = rf_q.presc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign pix       = rf_q.pix;
    assign ctrl_byte = rf_q.ctrl;
    assign presc     = rf_q.presc;
endmodule

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer #(
    parameter int PW      = 8,
    parameter int SYS_DIV = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clear,
    input  logic [1:0]    src,
    input  logic [PW-1:0] presc,
    input  logic          ext_clk,
    input  logic          rc_clk,
    output logic          slot
);
    localparam int DIV_W = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div_cnt;
        logic [PW-1:0]    pre_cnt;
        logic             ext_prev;
        logic             rc_prev;
    } tm_t;

    tm_t tm_d, tm_q;
    logic src_tick;
    logic sys_tick;

    always_comb begin
        tm_d          = tm_q;
        tm_d.ext_prev = ext_clk;
        tm_d.rc_prev  = rc_clk;
        sys_tick      = (tm_q.div_cnt == DIV_W'(SYS_DIV - 1));
        unique case (src)
            2'b00:   src_tick = sys_tick;
            2'b01:   src_tick = ext_clk & ~tm_q.ext_prev;
            default: src_tick = rc_clk & ~tm_q.rc_prev;
        endcase
        slot = run && src_tick && (tm_q.pre_cnt >= presc);
        if (clear) begin
            tm_d.div_cnt = '0;
            tm_d.pre_cnt = '0;
        end else if (run) begin
            tm_d.div_cnt = sys_tick ? '0 : tm_q.div_cnt + 1'b1;
            if (src_tick) begin
                tm_d.pre_cnt = slot ? '0 : tm_q.pre_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end
endmodule

// File: rtl/lcd_com_seq.sv
module lcd_com_seq #(
    parameter int NCOM = 4,
    localparam int CW  = (NCOM > 1) ? $clog2(NCOM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          slot,
    input  logic [CW-1:0] last,
    output logic [CW-1:0] com_idx,
    output logic          phase
);
    typedef struct packed {
        logic [CW-1:0] idx;
        logic          ph;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (clear) begin
            seq_d = '0;
        end else if (slot) begin
            if (seq_q.idx >= last) begin
                seq_d.idx = '0;
                seq_d.ph  = ~seq_q.ph;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign com_idx = seq_q.idx;
    assign phase   = seq_q.ph;
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map #(
    parameter int NCOM = 4,
    parameter int NSEG = 32,
    localparam int CW  = (NCOM > 1) ? $clog2(NCOM) : 1
) (
    input  logic                 en,
    input  logic [CW-1:0]        last,
    input  logic [CW-1:0]        com_idx,
    input  logic                 phase,
    input  logic [NCOM*NSEG-1:0] pix,
    output logic [NCOM*2-1:0]    com_lvl,
    output logic [NSEG*2-1:0]    seg_lvl
);
    import lcd_seq_pkg::*;

    lvl_t sel_l, unsel_l, dark_l, clear_l;

    always_comb begin
        sel_l = phase ? LVL_V0 : LVL_V3;
        dark_l = phase ? LVL_V3 : LVL_V0;
        if (last == '0) begin
            unsel_l = LVL_V0;
            clear_l = sel_l;
        end else begin
            unsel_l = phase ? LVL_V2 : LVL_V1;
            clear_l = phase ? LVL_V1 : LVL_V2;
        end
        for (int c = 0; c < NCOM; c++) begin
            if (!en || c > int'(last)) com_lvl[c*2 +: 2] = LVL_V0;
            else if (c == int'(com_idx)) com_lvl[c*2 +: 2] = sel_l;
            else com_lvl[c*2 +: 2] = unsel_l;
        end
        for (int s = 0; s < NSEG; s++) begin
            if (!en || s >= NSEG - int'(last)) seg_lvl[s*2 +: 2] = LVL_V0;
            else if (pix[int'(com_idx)*NSEG + s]) seg_lvl[s*2 +: 2] = dark_l;
            else seg_lvl[s*2 +: 2] = clear_l;
        end
    end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
    parameter int NCOM    = 4,
    parameter int NSEG    = 32,
    parameter int DW      = 8,
    parameter int SYS_DIV = 256,
    localparam int NREG   = NCOM * NSEG / DW,
    localparam int AW     = $clog2(NREG + 2),
    localparam int CW     = (NCOM > 1) ? $clog2(NCOM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              ext_clk,
    input  logic              rc_clk,
    input  logic              sleep_in,
    output logic [NCOM*2-1:0] com_lvl,
    output logic [NSEG*2-1:0] seg_lvl,
    output logic              vgen_en
);
    import lcd_seq_pkg::*;

    logic [NREG*DW-1:0] pix;
    logic [7:0]         ctrl_byte;
    logic [DW-1:0]      presc;
    ctrl_t              ctrl;
    logic               run, clear, slot, phase;
    logic [CW-1:0]      com_idx;

    lcd_regfile #(.NREG(NREG), .DW(DW), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .pix(pix),
        .ctrl_byte(ctrl_byte), .presc(presc)
    );

    always_comb begin
        ctrl  = decode_ctrl(ctrl_byte);
        clear = ~ctrl.en;
        run   = ctrl.en & ~(ctrl.slp & sleep_in);
    end

    lcd_slot_timer #(.PW(DW), .SYS_DIV(SYS_DIV)) timer_i (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(clear),
        .src(ctrl.src), .presc(presc), .ext_clk(ext_clk),
        .rc_clk(rc_clk), .slot(slot)
    );

    lcd_com_seq #(.NCOM(NCOM)) seq_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .slot(slot),
        .last(CW'(ctrl.mux)), .com_idx(com_idx), .phase(phase)
    );

    lcd_level_map #(.NCOM(NCOM), .NSEG(NSEG)) map_i (
        .en(ctrl.en), .last(CW'(ctrl.mux)), .com_idx(com_idx),
        .phase(phase), .pix(pix), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    assign vgen_en = ctrl.vgen;
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
    parameter int NCOM = 4,
    parameter int NSEG = 32,
    parameter int AW   = 5,
    parameter int DW   = 8,
    parameter int NREG = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_rdata,
    input logic              sleep_in,
    input logic [NCOM*2-1:0] com_lvl,
    input logic [NSEG*2-1:0] seg_lvl,
    input logic [7:0]        ctrl_byte
);
    logic       en, slp;
    logic [1:0] mux;
    logic       static_ok, unused_ok;
    int         sel_cnt;

    always_comb begin
        en  = ctrl_byte[7];
        slp = ctrl_byte[6];
        mux = ctrl_byte[1:0];
        static_ok = 1'b1;
        unused_ok = 1'b1;
        sel_cnt   = 0;
        for (int c = 0; c < NCOM; c++) begin
            if (com_lvl[c*2 +: 2] == 2'd1 || com_lvl[c*2 +: 2] == 2'd2) static_ok = 1'b0;
            if (c <= int'(mux) && (com_lvl[c*2 +: 2] == 2'd0 || com_lvl[c*2 +: 2] == 2'd3))
                sel_cnt++;
        end
        for (int s = 0; s < NSEG; s++) begin
            if (seg_lvl[s*2 +: 2] == 2'd1 || seg_lvl[s*2 +: 2] == 2'd2) static_ok = 1'b0;
            if (s >= NSEG - int'(mux) && seg_lvl[s*2 +: 2] != 2'd0) unused_ok = 1'b0;
        end
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (com_lvl == '0 && seg_lvl == '0)); // R3
    AST_STATIC_TWO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mux == 2'd0) |-> static_ok); // R5
    AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mux != 2'd0) |-> sel_cnt == 1); // R6
    AST_TAKEN_SEGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> unused_ok); // R7
    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && slp && sleep_in && !bus_we) |=> $stable(com_lvl)); // R11
    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) == NREG) |-> !bus_rdata[5]); // R2
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(
    .NCOM(NCOM), .NSEG(NSEG), .AW(AW), .DW(DW), .NREG(NREG)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .sleep_in(sleep_in), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl), .ctrl_byte(ctrl_byte)
);

// File: tb/lcd_mux_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_mux_seq_tb_top;
    localparam int A_CTRL  = 16;
    localparam int A_PRESC = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ext_clk = 1'b0;
    logic        rc_clk = 1'b0;
    logic        sleep_in = 1'b0;
    logic [7:0]  com_lvl;
    logic [63:0] seg_lvl;
    logic        vgen_en;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic [127:0] pix_m = '0;
    int m_idx = 0;
    int m_ph = 0;

    always #5 clk = ~clk;

    lcd_mux_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
        .rc_clk(rc_clk), .sleep_in(sleep_in), .com_lvl(com_lvl),
        .seg_lvl(seg_lvl), .vgen_en(vgen_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a < 16) pix_m[a*8 +: 8] = d;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = 5'(a);
        #1 d = bus_rdata;
    endtask

    task automatic pulse_rc();
        @(negedge clk) rc_clk = 1'b1;
        @(negedge clk) rc_clk = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk) ext_clk = 1'b1;
        @(negedge clk) ext_clk = 1'b0;
    endtask

    function automatic logic [1:0] e_com(int mux, int c);
        if (c > mux) return 2'd0;
        if (mux == 0 || c == m_idx) return (m_ph != 0) ? 2'd0 : 2'd3;
        return (m_ph != 0) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [1:0] e_seg(int mux, int s);
        logic dark;
        if (s >= 32 - mux) return 2'd0;
        dark = pix_m[m_idx*32 + s];
        if (dark) return (m_ph != 0) ? 2'd3 : 2'd0;
        if (mux == 0) return (m_ph != 0) ? 2'd0 : 2'd3;
        return (m_ph != 0) ? 2'd1 : 2'd2;
    endfunction

    task automatic chk_levels(input string req, input int mux);
        logic [63:0] ec, es;
        ec = '0; es = '0;
        for (int c = 0; c < 4; c++) ec[c*2 +: 2] = e_com(mux, c);
        for (int s = 0; s < 32; s++) es[s*2 +: 2] = e_seg(mux, s);
        #1;
        chk({req, " commons"}, {56'd0, com_lvl}, ec);
        chk({req, " segments"}, seg_lvl, es);
    endtask

    function automatic void advance(int mux);
        if (m_idx >= mux) begin m_idx = 0; m_ph ^= 1; end
        else m_idx++;
    endfunction

    task automatic start(input logic [7:0] ctrl);
        wr(A_CTRL, 8'h00);
        wr(A_CTRL, ctrl);
        m_idx = 0; m_ph = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(A_CTRL, d);
        chk("R1 ctrl reset", {56'd0, d}, 64'h0);
        chk("R1 vgen reset", {63'd0, vgen_en}, 64'h0);
        chk("R1 commons reset", {56'd0, com_lvl}, 64'h0);
        chk("R1 segments reset", seg_lvl, 64'h0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        for (int i = 0; i < 16; i++) wr(i, 8'(i * 29 + 8'h5A));
        for (int i = 0; i < 16; i += 5) begin
            rd(i, d);
            chk("R2 pixel readback", {56'd0, d}, {56'd0, 8'(i * 29 + 8'h5A)});
        end
        wr(A_CTRL, 8'h3C);
        rd(A_CTRL, d);
        chk("R2 rsvd bit5 reads 0", {56'd0, d}, 64'h1C);
        chk("R2 vgen follows bit4", {63'd0, vgen_en}, 64'h1);
        chk("R3 disabled commons", {56'd0, com_lvl}, 64'h0);
        chk("R3 disabled segments", seg_lvl, 64'h0);
        wr(A_PRESC, 8'hA7);
        rd(A_PRESC, d);
        chk("R2 prescaler readback", {56'd0, d}, 64'hA7);
        wr(A_PRESC, 8'h00);
    endtask

    task automatic t_static();
        start(8'h88);
        chk_levels("R5 R8 static half A", 0);
        pulse_rc(); advance(0);
        chk_levels("R5 static half B", 0);
        pulse_ext();
        chk_levels("R9 ext ignored with rc source", 0);
        pulse_rc(); advance(0);
        chk_levels("R4 static back to half A", 0);
    endtask

    task automatic t_mux(input int mux, input int steps);
        start(8'h88 | 8'(mux));
        chk_levels("R6 R7 R8 mux start", mux);
        for (int k = 0; k < steps; k++) begin
            pulse_rc(); advance(mux);
            chk_levels("R4 R6 R7 mux step", mux);
        end
    endtask

    task automatic t_presc();
        wr(A_PRESC, 8'd2);
        start(8'h89);
        pulse_rc(); pulse_rc();
        chk_levels("R10 no slot before p+1 ticks", 1);
        pulse_rc(); advance(1);
        chk_levels("R10 slot on tick p+1", 1);
        pulse_rc(); pulse_rc(); pulse_rc(); advance(1);
        chk_levels("R10 second slot", 1);
        wr(A_PRESC, 8'd0);
    endtask

    task automatic t_ext();
        start(8'h86);
        pulse_rc();
        chk_levels("R9 rc ignored with ext source", 2);
        pulse_ext(); advance(2);
        chk_levels("R9 ext edge advances", 2);
        pulse_ext(); advance(2);
        chk_levels("R9 ext edge advances again", 2);
    endtask

    task automatic t_sleep();
        start(8'hCB);
        sleep_in = 1'b1;
        pulse_rc(); pulse_rc();
        chk_levels("R11 sleep freezes", 3);
        wr(A_CTRL, 8'h8B);
        pulse_rc(); advance(3);
        chk_levels("R11 refresh continues during sleep", 3);
        sleep_in = 1'b0;
    endtask

    task automatic t_sysdiv();
        start(8'h80);
        repeat (240) @(negedge clk);
        chk_levels("R9 sysclk no slot before 256", 0);
        repeat (20) @(negedge clk);
        advance(0);
        chk_levels("R9 sysclk slot after 256", 0);
    endtask

    task automatic t_disable();
        start(8'h8B);
        pulse_rc(); advance(3);
        pulse_rc(); advance(3);
        wr(A_CTRL, 8'h0B);
        #1;
        chk("R3 off commons", {56'd0, com_lvl}, 64'h0);
        chk("R3 off segments", seg_lvl, 64'h0);
        wr(A_CTRL, 8'h8B);
        m_idx = 0; m_ph = 0;
        chk_levels("R3 restart at common 0 half A", 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_static();
        t_mux(1, 5);
        t_mux(2, 7);
        t_mux(3, 9);
        t_presc();
        t_ext();
        t_sleep();
        t_sysdiv();
        t_disable();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule